// File: doc/BRIEF.md
# Network Time-Code Master/Slave Unit

This unit holds the time-code register of a packet router and decides when a time-code goes out. In master mode an external tick input is brought through a synchronizer. On each rising edge of that tick, the unit increments the count field of its register and sends the result to every port. If the select-external line is high at that moment, the unit loads and sends the supplied 8-bit external value in its place.

In slave mode the unit watches codes arriving from any port. It accepts a code only when its count field is exactly one more than the count field of the register. An accepted code is forwarded to every port except the one it came on, and it is announced on an active-low tick output together with its value. A code that arrives out of sequence still overwrites the register, but it is neither forwarded nor announced. This stops a loop in the network from circulating codes forever.

A counter-clear input returns the register to zero. The clear outranks every other event that falls in the same cycle.

Top module: `timecode_unit`

## Requirements
- R1: While and after reset, before any event, `cur_time_o`, `tx_code_o` and `time_out_o` are 0, `tx_req_o` is all zeros and `tick_n_o` is high.
- R2: In master mode, a rising edge on `ext_tick_i` with `ext_sel_i` low is followed, on the third clock edge after the input changes, by a one-cycle `tx_req_o` of all ones. In that cycle `tx_code_o` and the register take the old register value with bits [5:0] incremented modulo 64 and bits [7:6] unchanged.
- R3: In master mode, if `ext_sel_i` is high when the synchronized tick edge is seen, `ext_time_i` is loaded into the register and sent on all ports in place of the incremented value.
- R4: Only a rising edge of the tick starts a distribution. Holding the tick high, or letting it fall, sends nothing and leaves the register unchanged.
- R5: `ctr_clear_i` high makes the register 0 at the next clock edge. It overrides a master tick edge or a received code in the same cycle, and no request or tick-out is produced for that event.
- R6: In slave mode, a received code whose bits [5:0] equal the register's bits [5:0] plus 1 modulo 64 (63 is followed by 0) is accepted one clock later. Bits [7:6] take no part in the comparison. On acceptance the register takes the full code, `tx_req_o` has bit p clear and all other bits set (p being the source port), `tx_code_o` and `time_out_o` carry the code, and `tick_n_o` is low.
- R7: In slave mode, a code that is out of sequence overwrites the register but leaves `tx_req_o` at zero and `tick_n_o` high.
- R8: When several ports present a code in the same cycle, the lowest-numbered port is taken and the others are ignored.
- R9: In master mode, received codes are ignored and `tick_n_o` stays high. In slave mode, the external tick is ignored.
- R10: `tx_req_o` and the low phase of `tick_n_o` each last one cycle per event. `time_out_o` holds its last value between announcements and equals `cur_time_o` whenever `tick_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_mode_i | input | 1 | 1 = master, 0 = slave |
| ext_tick_i | input | 1 | Asynchronous external tick; its rising edge triggers a master send |
| ext_sel_i | input | 1 | Use `ext_time_i` instead of the incremented value |
| ext_time_i | input | 8 | External time-code value |
| ctr_clear_i | input | 1 | Clears the time-code register to zero |
| rx_valid_i | input | NPORTS | Per-port strobe: a code has arrived |
| rx_code_i | input | 8*NPORTS | Per-port received code, port p in bits [8p+7:8p] |
| tx_req_o | output | NPORTS | Per-port one-cycle send request |
| tx_code_o | output | 8 | Code to send with `tx_req_o` |
| tick_n_o | output | 1 | Active-low external tick-out, one cycle per accepted code |
| time_out_o | output | 8 | Value of the last accepted code |
| cur_time_o | output | 8 | Current time-code register |

## Verification
The counter clear can land in the same cycle as a distribution decision, so the bench sets up that collision in both modes. In slave mode, the clear is driven together with a code that is in sequence. In master mode, the bench counts the synchronizer delay and raises the clear in exactly the cycle in which the detected tick edge is present. In both cases the result is correct only if the register reads zero, no port request appears and the tick-out stays high. A second collision tests two ports presenting codes at once: the request mask must exclude the lower-numbered port, and the register must hold that port's code.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int TC_W   = 8;
  localparam int CNT_W  = 6;
  localparam int FLAG_W = TC_W - CNT_W;

  typedef logic [TC_W-1:0] tcode_t;

  // next value of a code: count field +1 modulo 2**CNT_W, flags carried
  function automatic tcode_t tc_advance(input tcode_t c);
    logic [CNT_W-1:0] cnt;
    cnt = c[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1};
    return {c[TC_W-1:CNT_W], cnt};
  endfunction

  // true when rx is the direct successor of cur in the count field
  function automatic logic tc_follows(input tcode_t cur, input tcode_t rx);
    tcode_t nxt;
    nxt = tc_advance(cur);
    return rx[CNT_W-1:0] == nxt[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/tcu_tick_sync.sv
module tcu_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];
  end

  assign rise_o = chain[LAST] & ~prev;

endmodule

// File: rtl/tcu_rx_pick.sv
module tcu_rx_pick
  import tcu_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0]      valid_i,
  input  logic [NPORTS*TC_W-1:0] codes_i,
  output logic                   hit_o,
  output logic [NPORTS-1:0]      src_oh_o,
  output tcode_t                 code_o
);

  // walk from the top down so the lowest valid port wins
  always_comb begin
    hit_o    = 1'b0;
    src_oh_o = '0;
    code_o   = '0;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (valid_i[p]) begin
        hit_o       = 1'b1;
        src_oh_o    = '0;
        src_oh_o[p] = 1'b1;
        code_o      = codes_i[p*TC_W +: TC_W];
      end
    end
  end

endmodule

// File: rtl/tcu_core.sv
module tcu_core
  import tcu_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_i,
  input  logic              rise_i,
  input  logic              sel_i,
  input  tcode_t            ext_val_i,
  input  logic              clear_i,
  input  logic              hit_i,
  input  logic [NPORTS-1:0] src_oh_i,
  input  tcode_t            rx_code_i,
  output logic [NPORTS-1:0] tx_req_o,
  output tcode_t            tx_code_o,
  output logic              tick_n_o,
  output tcode_t            time_out_o,
  output tcode_t            cur_o,
  output logic              mst_evt_o,
  output logic              fwd_evt_o,
  output logic              oos_evt_o
);

  tcode_t cur_q;
  tcode_t mst_val;
  logic   slv_take;
  logic   in_seq;

  assign mst_evt_o = master_i & rise_i & ~clear_i;
  assign slv_take  = ~master_i & hit_i & ~clear_i;
  assign in_seq    = tc_follows(cur_q, rx_code_i);
  assign fwd_evt_o = slv_take & in_seq;
  assign oos_evt_o = slv_take & ~in_seq;
  assign mst_val   = sel_i ? ext_val_i : tc_advance(cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      tx_req_o   <= '0;
      tx_code_o  <= '0;
      tick_n_o   <= 1'b1;
      time_out_o <= '0;
    end else begin
      tx_req_o <= '0;
      tick_n_o <= 1'b1;
      if (clear_i) begin
        cur_q <= '0;
      end else if (mst_evt_o) begin
        cur_q     <= mst_val;
        tx_req_o  <= '1;
        tx_code_o <= mst_val;
      end else if (slv_take) begin
        cur_q <= rx_code_i;
        if (in_seq) begin
          tx_req_o   <= ~src_oh_i;
          tx_code_o  <= rx_code_i;
          tick_n_o   <= 1'b0;
          time_out_o <= rx_code_i;
        end
      end
    end
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/timecode_unit.sv
module timecode_unit
  import tcu_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   master_mode_i,
  input  logic                   ext_tick_i,
  input  logic                   ext_sel_i,
  input  logic [7:0]             ext_time_i,
  input  logic                   ctr_clear_i,
  input  logic [NPORTS-1:0]      rx_valid_i,
  input  logic [NPORTS*8-1:0]    rx_code_i,
  output logic [NPORTS-1:0]      tx_req_o,
  output logic [7:0]             tx_code_o,
  output logic                   tick_n_o,
  output logic [7:0]             time_out_o,
  output logic [7:0]             cur_time_o
);

  logic              tick_rise;
  logic              rx_hit;
  logic [NPORTS-1:0] src_oh;
  tcode_t            rx_pick;
  logic              mst_evt;
  logic              fwd_evt;
  logic              oos_evt;

  tcu_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_tick_i),
    .rise_o  (tick_rise)
  );

  tcu_rx_pick #(.NPORTS(NPORTS)) u_pick (
    .valid_i  (rx_valid_i),
    .codes_i  (rx_code_i),
    .hit_o    (rx_hit),
    .src_oh_o (src_oh),
    .code_o   (rx_pick)
  );

  tcu_core #(.NPORTS(NPORTS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_i   (master_mode_i),
    .rise_i     (tick_rise),
    .sel_i      (ext_sel_i),
    .ext_val_i  (ext_time_i),
    .clear_i    (ctr_clear_i),
    .hit_i      (rx_hit),
    .src_oh_i   (src_oh),
    .rx_code_i  (rx_pick),
    .tx_req_o   (tx_req_o),
    .tx_code_o  (tx_code_o),
    .tick_n_o   (tick_n_o),
    .time_out_o (time_out_o),
    .cur_o      (cur_time_o),
    .mst_evt_o  (mst_evt),
    .fwd_evt_o  (fwd_evt),
    .oos_evt_o  (oos_evt)
  );

endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode_i,
  input logic              ctr_clear_i,
  input logic [NPORTS-1:0] tx_req_o,
  input logic              tick_n_o,
  input logic [7:0]        time_out_o,
  input logic [7:0]        cur_time_o,
  input logic [NPORTS-1:0] src_oh,
  input logic              mst_evt,
  input logic              fwd_evt,
  input logic              oos_evt
);

  a_r2_all_ports: assert property (@(posedge clk) disable iff (!rst_n)
    mst_evt |=> tx_req_o == {NPORTS{1'b1}});

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear_i |=> cur_time_o == 8'd0 && tx_req_o == '0 && tick_n_o);

  a_r6_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_evt |=> tx_req_o == ~$past(src_oh) && !tick_n_o);

  a_r7_oos_silent: assert property (@(posedge clk) disable iff (!rst_n)
    oos_evt |=> tx_req_o == '0 && tick_n_o);

  a_r9_master_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode_i |=> tick_n_o);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(mst_evt || fwd_evt) |=> tx_req_o == '0);

  a_r10_time_match: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_n_o |-> time_out_o == cur_time_o);

endmodule

bind timecode_unit tcu_checker #(.NPORTS(NPORTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_mode_i (master_mode_i),
  .ctr_clear_i   (ctr_clear_i),
  .tx_req_o      (tx_req_o),
  .tick_n_o      (tick_n_o),
  .time_out_o    (time_out_o),
  .cur_time_o    (cur_time_o),
  .src_oh        (src_oh),
  .mst_evt       (mst_evt),
  .fwd_evt       (fwd_evt),
  .oos_evt       (oos_evt)
);

// File: tb/timecode_unit_bench.sv
`timescale 1ns/100ps
module timecode_unit_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         master_mode = 1'b0;
  logic         ext_tick = 1'b0;
  logic         ext_sel = 1'b0;
  logic [7:0]   ext_time = 8'h00;
  logic         ctr_clear = 1'b0;
  logic [N-1:0] rx_valid = '0;
  logic [N*8-1:0] rx_code = '0;
  logic [N-1:0] tx_req;
  logic [7:0]   tx_code;
  logic         tick_n;
  logic [7:0]   time_out;
  logic [7:0]   cur_time;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  timecode_unit #(.NPORTS(N), .SYNC_STAGES(2)) u_timecode_unit (
    .clk(clk), .rst_n(rst_n), .master_mode_i(master_mode),
    .ext_tick_i(ext_tick), .ext_sel_i(ext_sel), .ext_time_i(ext_time),
    .ctr_clear_i(ctr_clear), .rx_valid_i(rx_valid), .rx_code_i(rx_code),
    .tx_req_o(tx_req), .tx_code_o(tx_code), .tick_n_o(tick_n),
    .time_out_o(time_out), .cur_time_o(cur_time)
  );

  // slave walk: {port[1:0], code[7:0], forwarded}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 8'h01, 1'b1},
    {2'd2, 8'h02, 1'b1},
    {2'd1, 8'h45, 1'b0},
    {2'd3, 8'h06, 1'b1},
    {2'd0, 8'hC7, 1'b1},
    {2'd1, 8'h3F, 1'b0},
    {2'd2, 8'h40, 1'b1},
    {2'd3, 8'h40, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // raise the tick, optionally collide a clear with the detected edge;
  // returns at the negedge after the third posedge
  task automatic tick_rise(input logic sel, input logic [7:0] val, input logic clr);
    @(negedge clk);
    ext_tick = 1'b1; ext_sel = sel; ext_time = val;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R2 no early send", tx_req, 0);
    ctr_clear = clr;
    @(posedge clk); @(negedge clk);
    ctr_clear = 1'b0;
  endtask

  task automatic tick_fall();
    ext_tick = 1'b0; ext_sel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input int port, input logic [7:0] code);
    @(negedge clk);
    rx_valid = '0; rx_valid[port] = 1'b1;
    rx_code[port*8 +: 8] = code;
    @(posedge clk); @(negedge clk);
    rx_valid = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] exp_cur;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cur", cur_time, 0);
    chk("R1 req", tx_req, 0);
    chk("R1 tick", tick_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 code", tx_code, 0);
    chk("R1 time_out", time_out, 0);

    // R6 / R7 table walk in slave mode
    exp_cur = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] p; logic [7:0] c; logic f;
      {p, c, f} = VEC[i];
      send(int'(p), c);
      exp_cur = c;
      chk(f ? "R6 req" : "R7 req", tx_req, f ? ((~(4'b1 << p)) & 4'hF) : 4'h0);
      chk(f ? "R6 tick" : "R7 tick", tick_n, !f);
      chk("R6 R7 register", cur_time, exp_cur);
      if (f) begin
        chk("R6 tx_code", tx_code, c);
        chk("R6 time_out", time_out, c);
      end
      @(negedge clk);
      chk("R10 req pulse", tx_req, 0);
      chk("R10 tick pulse", tick_n, 1);
    end
    chk("R10 time_out held", time_out, 8'h40);

    // R8 two ports in one cycle, lowest wins
    @(negedge clk);
    rx_valid = 4'b1010;
    rx_code[1*8 +: 8] = 8'h01;
    rx_code[3*8 +: 8] = 8'h22;
    @(posedge clk); @(negedge clk);
    rx_valid = '0;
    chk("R8 req", tx_req, 4'b1101);
    chk("R8 register", cur_time, 8'h01);

    // R5 clear collides with an in-sequence code
    @(negedge clk);
    rx_valid = 4'b0001; rx_code[7:0] = 8'h02; ctr_clear = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_valid = '0; ctr_clear = 1'b0;
    chk("R5 slave clear reg", cur_time, 0);
    chk("R5 slave clear req", tx_req, 0);
    chk("R5 slave clear tick", tick_n, 1);

    // R9 slave ignores external tick
    tick_rise(1'b0, 8'h00, 1'b0);
    chk("R9 slave tick req", tx_req, 0);
    chk("R9 slave tick reg", cur_time, 0);
    tick_fall();

    // R9 master ignores received codes
    master_mode = 1'b1;
    send(0, 8'h01);
    chk("R9 master rx reg", cur_time, 0);
    chk("R9 master rx req", tx_req, 0);
    chk("R9 master rx tick", tick_n, 1);

    // R2 master increment
    tick_rise(1'b0, 8'h00, 1'b0);
    chk("R2 req", tx_req, 4'hF);
    chk("R2 code", tx_code, 8'h01);
    chk("R2 reg", cur_time, 8'h01);
    chk("R9 master tick high", tick_n, 1);
    // R4 held high: no further send
    repeat (3) begin
      @(negedge clk);
      chk("R4 held", tx_req, 0);
    end
    tick_fall();
    chk("R4 fall req", tx_req, 0);
    chk("R4 fall reg", cur_time, 8'h01);

    // R3 external value
    tick_rise(1'b1, 8'hBE, 1'b0);
    chk("R3 req", tx_req, 4'hF);
    chk("R3 code", tx_code, 8'hBE);
    chk("R3 reg", cur_time, 8'hBE);
    tick_fall();

    // R2 flags kept, count wraps 63 -> 0
    tick_rise(1'b0, 8'h00, 1'b0);
    chk("R2 flags code", tx_code, 8'hBF);
    tick_fall();
    tick_rise(1'b0, 8'h00, 1'b0);
    chk("R2 wrap code", tx_code, 8'h80);
    chk("R2 wrap reg", cur_time, 8'h80);
    tick_fall();

    // R5 clear collides with master edge
    tick_rise(1'b0, 8'h00, 1'b1);
    chk("R5 master clear reg", cur_time, 0);
    chk("R5 master clear req", tx_req, 0);
    tick_fall();
    tick_rise(1'b0, 8'h00, 1'b0);
    chk("R5 count after clear", tx_code, 8'h01);
    tick_fall();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule